// File: doc/BRIEF.md
# Runtime-Programmable Digital Trigger Pattern Engine

This block decides when an instrument's acquisition should trigger, based on a pool of one-bit channel signals: digital probe lines and the comparator outputs of analog channels. A crossbar first picks eight logical inputs out of the pool in a programmed order. Because of this, logical input 0 and logical input 1 always play the same roles, for example data and clock, whichever physical channels carry them. A small state machine then watches those inputs. It has a 4-bit state, four one-bit temp registers that remember earlier signal values, and nine 32-entry truth tables that compute the next state, the temp-register write enables and a fire decision.

All truth tables, crossbar selects and temp source selects live in one serial configuration chain. Software computes the chain contents offline and shifts them in one bit per cycle. The flops and the wiring stay fixed, so a new trigger condition needs no hardware rebuild. An arm input starts a search. A match gives a single-cycle trigger pulse and leaves the engine disarmed until it is armed again.

Top module: `trig_pattern_engine`

## Requirements
- R1: While rst_n is low, trig is 0. The state, the temp registers and every configuration bit are cleared, and the engine comes out of reset disarmed.
- R2: In every cycle with cfg_en high, the configuration chain shifts by one position toward bit 0 and cfg_din enters at the top bit (336 bits with the default parameters). After a full load, the first bit shifted in sits at bit 0. The layout is as follows. Table j occupies bits 32*j to 32*j+31, and entry a of that table is bit 32*j+a. Tables 0 to 3 give next-state bits 0 to 3, table 4 gives the fire bit, and tables 5 to 8 give the write enables of temps 0 to 3. Crossbar field k (4 bits) is at bit 288+4*k. Temp source field m (4 bits) is at bit 320+4*m.
- R3: Logical input k equals ch[s], where s is the unsigned value of crossbar field k.
- R4: Every table is read at the address {state[1], state[0], in[1], in[0], t} (MSB first). Here t is the temp register whose index is state[3:2].
- R5: In a cycle where the engine is armed, cfg_en and arm are low and the fire bit is 0, the state takes the values of tables 0 to 3.
- R6: In that same kind of cycle, every temp whose write-enable table reads 1 is loaded from its source. If field bit 3 is 1, the source is the constant held in field bit 0. If field bit 3 is 0, the source is logical input field[2:0]. Temps whose enable reads 0 hold their value.
- R7: In an armed cycle with cfg_en and arm low where the fire bit is 1, trig is 1 for exactly the next cycle. The state returns to 0 and the engine becomes disarmed. The temps hold their value.
- R8: arm high clears the state and all temps and arms the engine at the next edge, and trig is 0 after that edge. This takes priority over cfg_en and over any fire decision.
- R9: While disarmed, the state and temps hold their values and trig stays 0, even if the fire table reads 1.
- R10: While cfg_en is high and arm is low, the state and temps hold their values and trig stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Shift the configuration chain and hold the engine |
| cfg_din | input | 1 | Serial configuration data bit |
| arm | input | 1 | Clear the state and temps and arm the engine |
| ch | input | N_CH | Pool of one-bit channel signals |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
The checker assumes that reset is asserted before the first edge and that arm and cfg_en are synchronous to clk. Arm and cfg_en may overlap, so the hold property for configuration cycles excludes cycles with arm high, since arm wins. To stay inside these assumptions while still reaching the overlaps, the stimulus gives arm as sparse random pulses. It also inserts short cfg_en bursts in the middle of a search, in addition to full chain loads. Channel values are fully random on every cycle. Fire tables are made sparse so that searches run long enough to walk through many states before a match.

// File: rtl/trig_pattern_engine.sv
module trig_pattern_engine #(
  parameter int N_CH = 16,
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic            arm,
  input  logic [N_CH-1:0] ch,
  output logic            trig
);
  localparam int N_ST    = 4;
  localparam int N_TMP   = 4;
  localparam int DEPTH   = 32;
  localparam int N_LUT   = N_ST + 1 + N_TMP;
  localparam int SELW    = $clog2(N_CH);
  localparam int SRCW    = $clog2(N_IN) + 1;
  localparam int XB_OFS  = N_LUT * DEPTH;
  localparam int SRC_OFS = XB_OFS + N_IN * SELW;
  localparam int CFGW    = SRC_OFS + N_TMP * SRCW;

  logic [CFGW-1:0]  cfg_q;
  logic [N_ST-1:0]  st_q;
  logic [N_TMP-1:0] tmp_q;
  logic             armed_q, trig_q;
  logic [N_IN-1:0]  sel_in;
  logic [N_LUT-1:0] lut_o;
  logic [N_TMP-1:0] src_v, tmp_nxt;
  logic [4:0]       addr;
  logic             run, fire;

  for (genvar k = 0; k < N_IN; k++) begin : g_xbar
    logic [SELW-1:0] s;
    assign s = cfg_q[XB_OFS + k*SELW +: SELW];
    assign sel_in[k] = ch[s];
  end

  assign addr = {st_q[1:0], sel_in[1], sel_in[0], tmp_q[st_q[3:2]]};

  for (genvar j = 0; j < N_LUT; j++) begin : g_lut
    logic [DEPTH-1:0] tbl;
    assign tbl = cfg_q[j*DEPTH +: DEPTH];
    assign lut_o[j] = tbl[addr];
  end

  for (genvar m = 0; m < N_TMP; m++) begin : g_src
    logic [SRCW-1:0] f;
    assign f = cfg_q[SRC_OFS + m*SRCW +: SRCW];
    assign src_v[m] = f[SRCW-1] ? f[0] : sel_in[f[SRCW-2:0]];
  end

  assign fire    = lut_o[N_ST];
  assign tmp_nxt = (lut_o[N_LUT-1:N_ST+1] & src_v) | (~lut_o[N_LUT-1:N_ST+1] & tmp_q);
  assign run     = armed_q & ~cfg_en & ~arm;
  assign trig    = trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      st_q    <= '0;
      tmp_q   <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= {cfg_din, cfg_q[CFGW-1:1]};
      trig_q <= run & fire;
      if (arm) begin
        st_q    <= '0;
        tmp_q   <= '0;
        armed_q <= 1'b1;
      end else if (run) begin
        if (fire) begin
          st_q    <= '0;
          armed_q <= 1'b0;
        end else begin
          st_q  <= lut_o[N_ST-1:0];
          tmp_q <= tmp_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/trig_pattern_engine_chk.sv
module trig_pattern_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       arm,
  input logic       trig,
  input logic [3:0] st,
  input logic [3:0] tmp,
  input logic       armed
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R7
  fire_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (st == 4'd0) && !armed);

  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (st == 4'd0) && (tmp == 4'd0) && armed && !trig);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !arm) |=> $stable(st) && $stable(tmp) && !trig);

  // R9
  disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm) |=> $stable(st) && $stable(tmp) && !trig);
endmodule

bind trig_pattern_engine trig_pattern_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .arm(arm), .trig(trig),
  .st(st_q), .tmp(tmp_q), .armed(armed_q)
);

// File: tb/test_trig_pattern_engine.sv
`timescale 1ns/1ps
module test_trig_pattern_engine;
  localparam int NCH = 16;
  localparam int XB  = 288;
  localparam int SR  = 320;
  localparam int CW  = 336;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_din = 0, arm = 0;
  logic [NCH-1:0] ch = '0;
  logic trig;
  int total = 0, fails = 0;
  bit done = 0;

  logic [CW-1:0] m_cfg;
  logic [3:0] m_st, m_tmp;
  bit m_armed;

  trig_pattern_engine i_trig_pattern_engine (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .arm(arm), .ch(ch), .trig(trig));

  always #5 clk = ~clk;

  task automatic chk(input bit got, input bit exp, input string tag);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: trig=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit tbl(input logic [CW-1:0] c, input int j, input logic [4:0] a);
    return c[j*32 + a];
  endfunction

  // reference model of one clock edge, returns expected trig after it
  task automatic step(input bit a, input bit ce, input bit cd,
                      input logic [NCH-1:0] chv, output bit e);
    logic [7:0] si;
    logic [4:0] ad;
    logic [3:0] nst, nt;
    bit fire, run;
    for (int k = 0; k < 8; k++) si[k] = chv[m_cfg[XB + k*4 +: 4]];
    ad = {m_st[1:0], si[1], si[0], m_tmp[m_st[3:2]]};
    for (int b = 0; b < 4; b++) nst[b] = tbl(m_cfg, b, ad);
    fire = tbl(m_cfg, 4, ad);
    for (int m = 0; m < 4; m++) begin
      logic [3:0] f;
      bit v;
      f = m_cfg[SR + m*4 +: 4];
      v = f[3] ? f[0] : si[f[2:0]];
      nt[m] = tbl(m_cfg, 5 + m, ad) ? v : m_tmp[m];
    end
    run = m_armed && !ce && !a;
    e = run && fire;
    if (ce) m_cfg = {cd, m_cfg[CW-1:1]};
    if (a) begin m_st = 0; m_tmp = 0; m_armed = 1; end
    else if (run) begin
      if (fire) begin m_st = 0; m_armed = 0; end
      else begin m_st = nst; m_tmp = nt; end
    end
  endtask

  task automatic cyc(input bit a, input bit ce, input bit cd,
                     input logic [NCH-1:0] chv, input string tag);
    bit e;
    arm = a; cfg_en = ce; cfg_din = cd; ch = chv;
    step(a, ce, cd, chv, e);
    @(negedge clk);
    chk(trig, e, tag);
  endtask

  task automatic load(input logic [CW-1:0] v);
    for (int i = 0; i < CW; i++) cyc(0, 1, v[i], NCH'($urandom), "R10 R2");
  endtask

  initial begin
    logic [CW-1:0] v;
    void'($urandom(1234));
    m_cfg = '0; m_st = 0; m_tmp = 0; m_armed = 0;
    repeat (3) @(negedge clk);
    chk(trig, 0, "R1");
    rst_n = 1;
    // R1: reset leaves the engine disarmed and the chain cleared
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, NCH'($urandom), "R1");

    // R9: fire table all ones but engine not armed
    v = '0; v[4*32 +: 32] = '1;
    load(v);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, NCH'($urandom), "R9");
    cyc(1, 0, 0, '0, "R8");
    cyc(0, 0, 0, '0, "R7 fire");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, NCH'($urandom), "R7 single pulse");
    // R8: arm wins over cfg_en
    cyc(1, 1, 1, '0, "R8");

    // R3 R4: fire only at address 2 with in0 from ch5, in1 from ch9
    v = '0; v[4*32 + 2] = 1'b1;
    v[XB +: 4] = 4'd5; v[XB + 4 +: 4] = 4'd9;
    load(v);
    cyc(1, 0, 0, '0, "R8");
    cyc(0, 0, 0, 16'h0200, "R3 swapped roles");
    cyc(0, 0, 0, 16'h0000, "R4");
    cyc(0, 0, 0, 16'h0020, "R3 R4 match");
    cyc(0, 0, 0, 16'h0020, "R9");

    // R6: temp0 loads constant 1, fire at address 1
    v = '0; v[5*32 +: 32] = '1; v[4*32 + 1] = 1'b1;
    v[SR +: 4] = 4'b1001;
    load(v);
    cyc(1, 0, 0, '0, "R8");
    cyc(0, 0, 0, '0, "R6 load");
    cyc(0, 0, 0, '0, "R6 fire");

    // R5: state walks 0->1->2->3, fires in state 3 (addr 24..31)
    v = '0;
    for (int a = 0; a < 32; a++) begin
      logic [1:0] s;
      s = 2'(a >> 3);
      if (s != 3) begin v[0*32 + a] = ~s[0]; v[1*32 + a] = s[0] ^ s[1]; end
      else v[4*32 + a] = 1'b1;
    end
    load(v);
    cyc(1, 0, 0, '0, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, NCH'($urandom), "R5 walk");
    cyc(0, 0, 0, NCH'($urandom), "R5 fire");

    // random configurations with mixed arm pulses and cfg bursts
    for (int r = 0; r < 10; r++) begin
      for (int j = 0; j < 9; j++)
        v[j*32 +: 32] = (j == 4) ? ($urandom & $urandom & $urandom & $urandom) : $urandom;
      for (int k = 0; k < 12; k++) v[XB + k*4 +: 4] = 4'($urandom);
      load(v);
      cyc(1, 0, 0, NCH'($urandom), "R8");
      for (int i = 0; i < 400; i++) begin
        int p;
        p = $urandom_range(0, 99);
        if (p < 3) cyc(1, $urandom_range(0, 1), 1'($urandom), NCH'($urandom), "R8");
        else if (p < 6) cyc(0, 1, 1'($urandom), NCH'($urandom), "R10");
        else cyc(0, 0, 0, NCH'($urandom), "R4 R5 R6 R7 R9");
      end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule